// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every data beat of a memory burst. A start pulse carries the first column. On each following clock the block puts out one column address, with flags that mark the first and the last beat. The burst length (2, 4 or 8 beats) and the ordering (sequential or interleaved) come from a small mode image, which a register-write port loads.

The addresses never leave the aligned block whose size is the burst length. Only the low one, two or three column bits move, and the bits above them keep the value of the start column. A terminate input closes a burst early. A new start pulse that arrives during a burst drops the old burst and begins a new sequence.

Top module: `burst_col_seq`

## Requirements
- R1: After reset no beat is presented, and the mode image holds length 2 with sequential ordering.
- R2: The mode image uses write bits [2:0] as the length code (1 = 2 beats, 2 = 4 beats, 3 = 8 beats) and bit 3 as the ordering (0 = sequential, 1 = interleaved). Higher write bits are ignored.
- R3: While the stored length code is reserved (0 or 4..7), a start pulse given when idle produces no beat.
- R4: In sequential order, beat k has the low offset (s + k) mod L, where s is the start column's low bits and L is the length. Column bits at and above log2(L) equal the start column for the whole burst.
- R5: In interleaved order, beat k has the low offset s XOR k. The upper bits are kept as in R4.
- R6: The first beat is presented in the cycle after the start pulse is sampled, with beat_first high. Later beats follow on consecutive cycles, with beat_first low.
- R7: beat_last is high on beat L-1, and no beat follows it unless a new start was sampled.
- R8: When term is high during a beat, that beat carries beat_last and the burst ends. When term is high while idle, it has no effect.
- R9: A start pulse sampled during a burst truncates it. The current beat is not flagged last unless term is high, and the next cycle presents beat 0 of the new sequence.
- R10: Mode writes are dropped while a beat is presented. A burst always uses the mode image held before its start pulse, even when a write is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode image write strobe |
| mode_wdata | input | MODE_W | Mode image write value |
| start | input | 1 | Begin a burst at start_col |
| start_col | input | COL_W | Starting column |
| term | input | 1 | End the current burst on this beat |
| beat_valid | output | 1 | A beat column is presented |
| beat_col | output | COL_W | Column address of the current beat |
| beat_first | output | 1 | Current beat is beat 0 |
| beat_last | output | 1 | Current beat is the final one |

## Verification
The hardest case to reach is a mode write that lands in a cycle when the sequencer is busy, or in the very cycle that a start is accepted. To reach it, the stimulus places the write on the beat after a start and also pairs it with a start pulse. It then runs the next burst to show which image was used. Truncation and early termination are timed against the beat index, so that the flagged beat and the first beat of the new sequence fall on known cycles. Reserved length codes are written and followed by start pulses, and the bench watches the outputs for any beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int OFS_W = 3;

    typedef struct packed {
        logic       ok;
        logic [1:0] lg;
        logic       ilv;
    } burst_mode_t;

    function automatic logic [OFS_W-1:0] beat_offset(
        input logic [OFS_W-1:0] s,
        input logic [OFS_W-1:0] k,
        input logic             ilv
    );
        return ilv ? (s ^ k) : (s + k);
    endfunction

    function automatic logic [OFS_W-1:0] beat_limit(input logic [1:0] lg);
        return OFS_W'((4'd1 << lg) - 4'd1);
    endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import burst_seq_pkg::*;
#(
    parameter int MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    input  logic              busy,
    output burst_mode_t       mode
);
    typedef struct packed {
        logic [2:0] code;
        logic       ilv;
    } img_t;

    img_t img_d, img_q;

    always_comb begin
        img_d = img_q;
        if (wr_en && !busy) begin
            img_d.code = wr_data[2:0];
            img_d.ilv  = wr_data[3];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_q.code <= 3'd1;
            img_q.ilv  <= 1'b0;
        end else begin
            img_q <= img_d;
        end
    end

    always_comb begin
        mode.ilv = img_q.ilv;
        unique case (img_q.code)
            3'd1:    begin mode.ok = 1'b1; mode.lg = 2'd1; end
            3'd2:    begin mode.ok = 1'b1; mode.lg = 2'd2; end
            3'd3:    begin mode.ok = 1'b1; mode.lg = 2'd3; end
            default: begin mode.ok = 1'b0; mode.lg = 2'd1; end
        endcase
    end

    // R10
    mode_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode));
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [OFS_W-1:0] k,
    input  logic [1:0]       lg,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [OFS_W-1:0] ofs;

    assign ofs = beat_offset(base[OFS_W-1:0], k, ilv);

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        if (b < OFS_W) begin : g_low
            assign col[b] = (b < int'(lg)) ? ofs[b] : base[b];
        end else begin : g_high
            assign col[b] = base[b];
        end
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              term,
    output logic              beat_valid,
    output logic [COL_W-1:0]  beat_col,
    output logic              beat_first,
    output logic              beat_last
);
    typedef struct packed {
        logic             act;
        logic [OFS_W-1:0] k;
        logic [COL_W-1:0] base;
        logic [1:0]       lg;
        logic             ilv;
    } seq_t;

    seq_t        st_d, st_q;
    burst_mode_t mode;
    logic        at_end;

    burst_mode_reg #(.MODE_W(MODE_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_we),
        .wr_data (mode_wdata),
        .busy    (st_q.act),
        .mode    (mode)
    );

    burst_col_map #(.COL_W(COL_W)) u_map (
        .base (st_q.base),
        .k    (st_q.k),
        .lg   (st_q.lg),
        .ilv  (st_q.ilv),
        .col  (beat_col)
    );

    assign at_end     = st_q.act && ((st_q.k == beat_limit(st_q.lg)) || term);
    assign beat_valid = st_q.act;
    assign beat_first = st_q.act && (st_q.k == '0);
    assign beat_last  = at_end;

    always_comb begin
        st_d = st_q;
        if (start && mode.ok) begin
            st_d.act  = 1'b1;
            st_d.k    = '0;
            st_d.base = start_col;
            st_d.lg   = mode.lg;
            st_d.ilv  = mode.ilv;
        end else if (at_end) begin
            st_d.act = 1'b0;
            st_d.k   = '0;
        end else if (st_q.act) begin
            st_d.k = st_q.k + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            st_q.lg <= 2'd1;
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    end_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !start) |=> !beat_valid);

    // R6
    beats_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last) |=> beat_valid);

    // R4
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last && !start) |=> $stable(beat_col[COL_W-1:OFS_W]));

    // R3
    reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_valid && start && !mode.ok) |=> !beat_valid);

    // R9
    restart_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode.ok) |=> (beat_first && beat_col == $past(start_col)));
endmodule

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
    localparam int COL_W  = 10;
    localparam int MODE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              mode_we;
    logic [MODE_W-1:0] mode_wdata;
    logic              start;
    logic [COL_W-1:0]  start_col;
    logic              term;
    logic              beat_valid;
    logic [COL_W-1:0]  beat_col;
    logic              beat_first;
    logic              beat_last;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [COL_W-1:0] col;
        bit               first;
        bit               last;
        string            tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W), .MODE_W(MODE_W)) uut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .start(start), .start_col(start_col), .term(term),
        .beat_valid(beat_valid), .beat_col(beat_col),
        .beat_first(beat_first), .beat_last(beat_last)
    );

    function automatic logic [COL_W-1:0] ecol(input logic [COL_W-1:0] b,
                                              input int lg, input bit ilv, input int k);
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] lo;
        mask = COL_W'((1 << lg) - 1);
        lo   = ilv ? ((b ^ COL_W'(k)) & mask) : ((b + COL_W'(k)) & mask);
        return (b & ~mask) | lo;
    endfunction

    task automatic push_burst(input logic [COL_W-1:0] b, input int lg, input bit ilv,
                              input int n, input bit last_on_final, input string tag);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.col   = ecol(b, lg, ilv, k);
            e.first = (k == 0);
            e.last  = last_on_final && (k == n - 1);
            e.tag   = tag;
            q.push_back(e);
        end
    endtask

    task automatic tick(input bit st, input logic [COL_W-1:0] c, input bit tm,
                        input bit we, input logic [MODE_W-1:0] wd);
        start = st; start_col = c; term = tm; mode_we = we; mode_wdata = wd;
        @(negedge clk);
        start = 1'b0; term = 1'b0; mode_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, '0, 1'b0, 1'b0, '0);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: samples 3 ns after each falling edge, away from the rising edge
    always begin
        @(negedge clk);
        #3;
        if (rst_n && beat_valid && !done) begin
            if (q.size() == 0) begin
                check(1'b0, "R3/R7 unexpected beat", int'(beat_col), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(beat_col == e.col && beat_first == e.first && beat_last == e.last,
                      e.tag, int'({beat_first, beat_last, beat_col}),
                      int'({e.first, e.last, e.col}));
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 0; start_col = '0; term = 0; mode_we = 0; mode_wdata = '0;
        repeat (3) @(negedge clk);
        #3;
        check(beat_valid == 1'b0, "R1 reset idle", beat_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1 R2 default mode: length 2 sequential
        push_burst(10'h005, 1, 0, 2, 1, "R1 default len2 seq");
        tick(1, 10'h005, 0, 0, '0); idle(3);

        // R2 R4 length 4 sequential with wrap
        tick(0, '0, 0, 1, 8'h02);
        push_burst(10'h00E, 2, 0, 4, 1, "R4 len4 seq wrap");
        tick(1, 10'h00E, 0, 0, '0); idle(5);

        // R4 R7 length 8 sequential
        tick(0, '0, 0, 1, 8'h03);
        push_burst(10'h01D, 3, 0, 8, 1, "R4 len8 seq");
        tick(1, 10'h01D, 0, 0, '0); idle(9);

        // R5 length 8 interleaved; higher write bits ignored (R2)
        tick(0, '0, 0, 1, 8'hFB);
        push_burst(10'h31D, 3, 1, 8, 1, "R5 len8 ilv");
        tick(1, 10'h31D, 0, 0, '0); idle(9);

        // R5 length 4 interleaved
        tick(0, '0, 0, 1, 8'h0A);
        push_burst(10'h022, 2, 1, 4, 1, "R5 len4 ilv");
        tick(1, 10'h022, 0, 0, '0); idle(5);

        // R8 terminate on beat 2 of a length-8 burst
        tick(0, '0, 0, 1, 8'h03);
        push_burst(10'h01D, 3, 0, 3, 1, "R8 term beat2");
        tick(1, 10'h01D, 0, 0, '0);
        idle(2);
        tick(0, '0, 1, 0, '0);
        idle(9);

        // R9 new start during beat 1 of a length-4 burst
        tick(0, '0, 0, 1, 8'h02);
        push_burst(10'h040, 2, 0, 2, 0, "R9 truncated");
        push_burst(10'h053, 2, 0, 4, 1, "R9 restart");
        tick(1, 10'h040, 0, 0, '0);
        idle(1);
        tick(1, 10'h053, 0, 0, '0);
        idle(6);

        // R3 reserved codes 4 and 0
        tick(0, '0, 0, 1, 8'h04);
        tick(1, 10'h011, 0, 0, '0); idle(4);
        check(beat_valid == 1'b0, "R3 code4 no beat", beat_valid, 0);
        tick(0, '0, 0, 1, 8'h00);
        tick(1, 10'h011, 0, 0, '0); idle(4);
        check(beat_valid == 1'b0, "R3 code0 no beat", beat_valid, 0);

        // R10 write during a burst is dropped
        tick(0, '0, 0, 1, 8'h03);
        push_burst(10'h060, 3, 0, 8, 1, "R10 busy write burst");
        tick(1, 10'h060, 0, 0, '0);
        tick(0, '0, 0, 1, 8'h01);
        idle(9);
        push_burst(10'h070, 3, 0, 8, 1, "R10 mode kept len8");
        tick(1, 10'h070, 0, 0, '0); idle(9);

        // R10 write with start in one cycle: burst uses prior image
        push_burst(10'h088, 3, 0, 8, 1, "R10 same-cycle prior mode");
        tick(1, 10'h088, 0, 1, 8'h01);
        idle(9);
        push_burst(10'h091, 1, 0, 2, 1, "R10 new mode len2");
        tick(1, 10'h091, 0, 0, '0); idle(3);

        // R8 terminate while idle has no effect
        tick(0, '0, 1, 0, '0);
        idle(2);
        check(beat_valid == 1'b0, "R8 idle term", beat_valid, 0);
        push_burst(10'h0A4, 1, 0, 2, 1, "R8 after idle term");
        tick(1, 10'h0A4, 0, 0, '0); idle(3);

        check(q.size() == 0, "R7 all beats seen", q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule